// File: doc/BRIEF.md
# Six-Slot Statically Scheduled Issue and Writeback Core

This core takes one wide instruction bundle per clock cycle. The bundle carries six operation slots. Each slot is tied to one class of function unit: two integer slots, two memory slots and two arithmetic slots. The arithmetic slots stand in for floating point and use integer add and multiply. Each slot reads its two source registers from a shared 32-entry register file when the bundle issues. Its result then travels down a pipeline whose length is fixed by the slot's class, and it writes back exactly that many cycles later. The memory slots use a small internal data memory.

The core has no hazard detection, no interlocks and no reordering. A consumer that issues too early reads the old register or memory contents, so correct programs rely entirely on the schedule built by the producer of the bundles. Bundles arrive as a valid-only stream. There is no ready signal and issue never stalls: a bundle presented with `bundle_valid` high is taken on that clock edge. Register writes are reported on a per-slot writeback result stream (`wb_valid`, `wb_rd`, `wb_data`). This stream is also valid-only and cannot be back-pressured; each report is held for exactly one cycle.

Timing convention: an operation of latency L in a bundle taken at edge t writes its destination at edge t+L-1. The first bundle that sees the new value is the one taken at edge t+L. The write is reported on the writeback stream during the cycle that follows edge t+L-1.

Top module: `vliw_core`

## Requirements
- R1: `bundle` is 192 bits wide, and slot k occupies bits [32k+31:32k]. Slots 0 and 1 are integer, slots 2 and 3 are memory, and slots 4 and 5 are arithmetic. Within a slot, bits [31:28] hold the opcode, [27:23] rd, [22:18] rs1, [17:13] rs2 and [12:0] a two's-complement immediate that is sign-extended. Opcodes: 0 NOP, 1 ADD, 2 ADDI, 3 SUB, 4 LD, 5 ST, 6 FADD, 7 FMUL.
- R2: The integer slots execute ADD (rs1+rs2), ADDI (rs1+imm) and SUB (rs1-rs2) with latency 1.
- R3: LD reads word (rs1+imm) mod 64 of the data memory at issue and writes it to rd with latency 3. ST writes rs2 to word (rs1+imm) mod 64 at edge t+2, so a load taken at edge t+2 or earlier reads the old word.
- R4: The arithmetic slots execute FADD (rs1+rs2) and FMUL (low 32 bits of rs1*rs2) with latency 4.
- R5: All six slots of a bundle read the register values as they stood before that bundle, so a write by one slot is never seen by another slot of the same bundle.
- R6: There are no interlocks. A bundle is taken on every edge where `bundle_valid` is high, and reading a register whose write is still in flight returns its old value.
- R7: A NOP, an opcode that does not belong to the slot's class, and any slot of a bundle presented with `bundle_valid` low change no register and no memory word, and raise no `wb_valid`.
- R8: Register 0 always reads as zero. Writes to it are dropped and are not reported on the writeback stream.
- R9: When two register writes reach the same register on the same edge, including writes from different latency classes, the lower-numbered slot wins.
- R10: When both memory slots store to the same word on the same edge, slot 2 wins.
- R11: For every register write, `wb_valid[k]` is high for one cycle with `wb_rd[5k+4:5k]` = rd and `wb_data[32k+31:32k]` = value, where k is the slot that produced the write.
- R12: After reset all registers and memory words are zero, no result is in flight, and `wb_valid` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bundle_valid | input | 1 | Bundle present; it is taken on this edge with no stall |
| bundle | input | 192 | Six 32-bit slot encodings |
| wb_valid | output | 6 | Per-slot register-write report |
| wb_rd | output | 30 | Per-slot destination register index |
| wb_data | output | 192 | Per-slot written value |

## Verification
The embedded properties assume that `bundle_valid` stays low while reset is applied, and that the integer latency keeps its default of 1, since the integer writeback properties are built only in that configuration. The stimulus builds every slot word through a single encoder that follows the R1 field layout, holds `bundle_valid` low during reset, and issues a bundle (often an all-NOP one) on every cycle so that no bundle is taken twice. Corner schedules (same-bundle reads, under-padded consumers, collisions across latency classes) are written by hand so that each one lands on a known edge.

// File: rtl/vliw_pkg.sv
package vliw_pkg;
  localparam int XLEN   = 32;
  localparam int RIDX_W = 5;
  localparam int IMM_W  = 13;
  localparam int NSLOT  = 6;

  typedef enum logic [3:0] {
    OP_NOP = 4'd0, OP_ADD = 4'd1, OP_ADDI = 4'd2, OP_SUB = 4'd3,
    OP_LD  = 4'd4, OP_ST  = 4'd5, OP_FADD = 4'd6, OP_FMUL = 4'd7
  } opc_e;

  typedef enum logic [1:0] { CLS_INT, CLS_MEM, CLS_ARI } cls_e;

  typedef struct packed {
    logic [3:0]        opc;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rs1;
    logic [RIDX_W-1:0] rs2;
    logic [IMM_W-1:0]  imm;
  } slot_t;

  typedef struct packed {
    logic              we;
    logic [RIDX_W-1:0] rd;
    logic [XLEN-1:0]   data;
  } ret_t;

  function automatic cls_e slot_class(int s);
    if (s < 2) return CLS_INT;
    if (s < 4) return CLS_MEM;
    return CLS_ARI;
  endfunction

  function automatic logic opc_fits(cls_e c, logic [3:0] o);
    case (c)
      CLS_INT: return (o == OP_ADD) || (o == OP_ADDI) || (o == OP_SUB);
      CLS_MEM: return (o == OP_LD) || (o == OP_ST);
      default: return (o == OP_FADD) || (o == OP_FMUL);
    endcase
  endfunction

  function automatic ret_t exec_op(cls_e c, slot_t o, logic [XLEN-1:0] a,
                                   logic [XLEN-1:0] b, logic [XLEN-1:0] ld);
    ret_t r;
    logic [XLEN-1:0] sx;
    r  = '0;
    sx = {{(XLEN-IMM_W){o.imm[IMM_W-1]}}, o.imm};
    if (opc_fits(c, o.opc)) begin
      r.rd = o.rd;
      case (o.opc)
        OP_ADD:  begin r.we = 1'b1; r.data = a + b;  end
        OP_ADDI: begin r.we = 1'b1; r.data = a + sx; end
        OP_SUB:  begin r.we = 1'b1; r.data = a - b;  end
        OP_LD:   begin r.we = 1'b1; r.data = ld;     end
        OP_FADD: begin r.we = 1'b1; r.data = a + b;  end
        OP_FMUL: begin r.we = 1'b1; r.data = a * b;  end
        default: r.we = 1'b0;
      endcase
    end
    if (o.rd == '0) r.we = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/vliw_lat_pipe.sv
module vliw_lat_pipe #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign q = d;
    end else begin : g_regs
      logic [DEPTH-1:0][W-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg <= '0;
        end else begin
          stg[0] <= d;
          for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
      end
      assign q = stg[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/vliw_regfile.sv
module vliw_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  parameter int NRD  = 12,
  parameter int NWR  = 6,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NRD-1:0][AW-1:0]  rd_adr,
  output logic [NRD-1:0][W-1:0]   rd_dat,
  input  logic [NWR-1:0]          wr_en,
  input  logic [NWR-1:0][AW-1:0]  wr_adr,
  input  logic [NWR-1:0][W-1:0]   wr_dat
);
  logic [NREG-1:0][W-1:0] regs;

  // Highest port written first so port 0 lands last and wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else begin
      for (int p = NWR - 1; p >= 0; p--)
        if (wr_en[p] && (wr_adr[p] != '0)) regs[wr_adr[p]] <= wr_dat[p];
    end
  end

  generate
    for (genvar r = 0; r < NRD; r++) begin : g_rd
      assign rd_dat[r] = regs[rd_adr[r]];
    end
  endgenerate

  // R8: register 0 is never written
  a_r8_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
    regs[0] == '0);

  generate
    for (genvar p = 1; p < NWR; p++) begin : g_prio
      // R9: port 0 wins a same-edge collision
      a_r9_low_slot_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[0] && wr_en[p] && (wr_adr[0] == wr_adr[p]) && (wr_adr[0] != '0))
        |=> regs[$past(wr_adr[0])] == $past(wr_dat[0]));
    end
  endgenerate
endmodule

// File: rtl/vliw_dmem.sv
module vliw_dmem #(
  parameter int WORDS = 64,
  parameter int W     = 32,
  parameter int NP    = 2,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NP-1:0][AW-1:0]  ld_adr,
  output logic [NP-1:0][W-1:0]   ld_dat,
  input  logic [NP-1:0]          st_en,
  input  logic [NP-1:0][AW-1:0]  st_adr,
  input  logic [NP-1:0][W-1:0]   st_dat
);
  logic [WORDS-1:0][W-1:0] mem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '0;
    end else begin
      for (int p = NP - 1; p >= 0; p--)
        if (st_en[p]) mem[st_adr[p]] <= st_dat[p];
    end
  end

  generate
    for (genvar p = 0; p < NP; p++) begin : g_ld
      assign ld_dat[p] = mem[ld_adr[p]];
    end
    for (genvar p = 1; p < NP; p++) begin : g_prio
      // R10: the first memory slot wins a same-word store collision
      a_r10_store_low_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (st_en[0] && st_en[p] && (st_adr[0] == st_adr[p]))
        |=> mem[$past(st_adr[0])] == $past(st_dat[0]));
    end
  endgenerate
endmodule

// File: rtl/vliw_core.sv
module vliw_core
  import vliw_pkg::*;
#(
  parameter int MEM_WORDS = 64,
  parameter int LAT_INT   = 1,
  parameter int LAT_MEM   = 3,
  parameter int LAT_ARI   = 4,
  localparam int MEM_AW   = $clog2(MEM_WORDS),
  localparam int NRD      = 2 * NSLOT
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bundle_valid,
  input  logic [NSLOT*XLEN-1:0]     bundle,
  output logic [NSLOT-1:0]          wb_valid,
  output logic [NSLOT*RIDX_W-1:0]   wb_rd,
  output logic [NSLOT*XLEN-1:0]     wb_data
);
  typedef struct packed {
    logic              en;
    logic [MEM_AW-1:0] adr;
    logic [XLEN-1:0]   dat;
  } st_t;

  slot_t ops [NSLOT];
  ret_t  issue_r  [NSLOT];
  ret_t  retire_r [NSLOT];

  logic [NRD-1:0][RIDX_W-1:0] rf_radr;
  logic [NRD-1:0][XLEN-1:0]   rf_rdat;
  logic [NSLOT-1:0]             rf_we;
  logic [NSLOT-1:0][RIDX_W-1:0] rf_wa;
  logic [NSLOT-1:0][XLEN-1:0]   rf_wd;

  logic [1:0][MEM_AW-1:0] ld_adr;
  logic [1:0][XLEN-1:0]   ld_dat;
  logic [1:0]             st_en;
  logic [1:0][MEM_AW-1:0] st_adr;
  logic [1:0][XLEN-1:0]   st_dat;

  generate
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      localparam cls_e CLS = slot_class(s);
      localparam int   LAT = (CLS == CLS_INT) ? LAT_INT :
                             (CLS == CLS_MEM) ? LAT_MEM : LAT_ARI;

      assign ops[s]           = bundle_valid ? slot_t'(bundle[XLEN*s +: XLEN]) : '0;
      assign rf_radr[2*s]     = ops[s].rs1;
      assign rf_radr[2*s + 1] = ops[s].rs2;

      if (CLS == CLS_MEM) begin : g_mem
        localparam int M = s - 2;
        st_t st_issue, st_retire;
        assign ld_adr[M] = rf_rdat[2*s][MEM_AW-1:0] + ops[s].imm[MEM_AW-1:0];
        assign issue_r[s] = exec_op(CLS, ops[s], rf_rdat[2*s], rf_rdat[2*s+1], ld_dat[M]);
        assign st_issue.en  = (ops[s].opc == OP_ST);
        assign st_issue.adr = ld_adr[M];
        assign st_issue.dat = rf_rdat[2*s + 1];
        vliw_lat_pipe #(.W($bits(st_t)), .DEPTH(LAT - 1)) u_st_pipe (
          .clk(clk), .rst_n(rst_n), .d(st_issue), .q(st_retire));
        assign st_en[M]  = st_retire.en;
        assign st_adr[M] = st_retire.adr;
        assign st_dat[M] = st_retire.dat;
      end else begin : g_alu
        assign issue_r[s] = exec_op(CLS, ops[s], rf_rdat[2*s], rf_rdat[2*s+1], '0);
      end

      vliw_lat_pipe #(.W($bits(ret_t)), .DEPTH(LAT - 1)) u_pipe (
        .clk(clk), .rst_n(rst_n), .d(issue_r[s]), .q(retire_r[s]));

      assign rf_we[s] = retire_r[s].we;
      assign rf_wa[s] = retire_r[s].rd;
      assign rf_wd[s] = retire_r[s].data;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wb_valid[s]                <= 1'b0;
          wb_rd[RIDX_W*s +: RIDX_W]  <= '0;
          wb_data[XLEN*s +: XLEN]    <= '0;
        end else begin
          wb_valid[s]                <= retire_r[s].we;
          wb_rd[RIDX_W*s +: RIDX_W]  <= retire_r[s].rd;
          wb_data[XLEN*s +: XLEN]    <= retire_r[s].data;
        end
      end

      if (CLS == CLS_INT && LAT_INT == 1) begin : g_int_chk
        // R2: a writing integer op is reported on the next edge under its own slot
        a_r2_int_report: assert property (@(posedge clk) disable iff (!rst_n)
          (((ops[s].opc == OP_ADD) || (ops[s].opc == OP_ADDI) || (ops[s].opc == OP_SUB))
           && (ops[s].rd != '0))
          |=> (wb_valid[s] && (wb_rd[RIDX_W*s +: RIDX_W] == $past(ops[s].rd))));
        // R7: an idle bundle produces no integer report
        a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
          !bundle_valid |=> !wb_valid[s]);
      end
    end
  endgenerate

  vliw_regfile #(.NREG(32), .W(XLEN), .NRD(NRD), .NWR(NSLOT)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .rd_adr(rf_radr), .rd_dat(rf_rdat),
    .wr_en(rf_we), .wr_adr(rf_wa), .wr_dat(rf_wd));

  vliw_dmem #(.WORDS(MEM_WORDS), .W(XLEN), .NP(2)) u_dmem (
    .clk(clk), .rst_n(rst_n),
    .ld_adr(ld_adr), .ld_dat(ld_dat),
    .st_en(st_en), .st_adr(st_adr), .st_dat(st_dat));
endmodule

// File: tb/vliw_core_tb_top.sv
module vliw_core_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bundle_valid = 1'b0;
  logic [191:0] bundle = '0;
  logic [5:0]   wb_valid;
  logic [29:0]  wb_rd;
  logic [191:0] wb_data;

  always #4 clk = ~clk;

  vliw_core dut_i (
    .clk(clk), .rst_n(rst_n), .bundle_valid(bundle_valid), .bundle(bundle),
    .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_data(wb_data));

  int checks = 0;
  int errors = 0;
  int edge_n = 0;
  int applied = 0;
  bit done = 0;

  typedef struct { int due; int slot; logic [4:0] rd; logic [31:0] data; } exp_t;
  exp_t sb [$];

  logic [31:0] ref_rf  [32];
  logic [31:0] ref_mem [64];
  bit          pw_v [16][6];
  logic [4:0]  pw_rd [16][6];
  logic [31:0] pw_dt [16][6];
  bit          ps_v [16][2];
  logic [5:0]  ps_ad [16][2];
  logic [31:0] ps_dt [16][2];
  logic [31:0] bw [6];

  localparam int NOP = 0, ADD = 1, ADDI = 2, SUB = 3, LD = 4, ST = 5, FADD = 6, FMUL = 7;

  always @(posedge clk) if (rst_n) edge_n <= edge_n + 1;

  function automatic logic [31:0] mk(int o, int rd, int rs1, int rs2, int imm);
    return {o[3:0], rd[4:0], rs1[4:0], rs2[4:0], imm[12:0]};
  endfunction

  function automatic int lat(int s);
    return (s < 2) ? 1 : (s < 4) ? 3 : 4;
  endfunction

  function automatic bit fits(int s, int o);
    if (s < 2) return (o == ADD) || (o == ADDI) || (o == SUB);
    if (s < 4) return (o == LD) || (o == ST);
    return (o == FADD) || (o == FMUL);
  endfunction

  task automatic apply_upto(int e);
    while (applied < e) begin
      applied++;
      for (int s = 5; s >= 0; s--)
        if (pw_v[applied%16][s]) begin
          ref_rf[pw_rd[applied%16][s]] = pw_dt[applied%16][s];
          pw_v[applied%16][s] = 0;
        end
      for (int m = 1; m >= 0; m--)
        if (ps_v[applied%16][m]) begin
          ref_mem[ps_ad[applied%16][m]] = ps_dt[applied%16][m];
          ps_v[applied%16][m] = 0;
        end
    end
  endtask

  // Driver: model the bundle per the requirements, push expected reports, drive it.
  task automatic go(bit v = 1);
    int t;
    @(negedge clk);
    t = edge_n + 1;
    apply_upto(t - 1);
    for (int s = 0; s < 6; s++) begin
      int o, rd, due;
      logic [31:0] a, b, sx, d;
      logic [5:0] ea;
      bit wr;
      o  = int'(bw[s][31:28]);
      rd = int'(bw[s][27:23]);
      a  = ref_rf[bw[s][22:18]];
      b  = ref_rf[bw[s][17:13]];
      sx = {{19{bw[s][12]}}, bw[s][12:0]};
      ea = 6'(a + sx);
      wr = 0; d = '0;
      if (v && fits(s, o)) begin
        case (o)
          ADD:  begin wr = 1; d = a + b;  end
          ADDI: begin wr = 1; d = a + sx; end
          SUB:  begin wr = 1; d = a - b;  end
          LD:   begin wr = 1; d = ref_mem[ea]; end
          ST:   begin
                  ps_v[(t+2)%16][s-2] = 1; ps_ad[(t+2)%16][s-2] = ea;
                  ps_dt[(t+2)%16][s-2] = b;
                end
          FADD: begin wr = 1; d = a + b;  end
          FMUL: begin wr = 1; d = a * b;  end
          default: wr = 0;
        endcase
      end
      if (wr && rd != 0) begin
        due = t + lat(s) - 1;
        pw_v[due%16][s] = 1; pw_rd[due%16][s] = 5'(rd); pw_dt[due%16][s] = d;
        sb.push_back('{due, s, 5'(rd), d});
      end
    end
    for (int s = 0; s < 6; s++) bundle[32*s +: 32] = bw[s];
    bundle_valid = v;
    for (int s = 0; s < 6; s++) bw[s] = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) go(1);
  endtask

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %0h exp %0h", req, act, exp);
    end
  endtask

  // Read register r through the normal datapath: ADDI r,r,0 in slot 0.
  task automatic probe(int r, logic [31:0] exp, string req);
    bw[0] = mk(ADDI, r, r, 0, 0);
    go(1);
    @(posedge clk); #2;
    if (r == 0) chk(wb_valid[0] == 1'b0, req, {31'd0, wb_valid[0]}, 32'd0);
    else chk(wb_valid[0] && wb_data[31:0] == exp, req, wb_data[31:0], exp);
  endtask

  // Monitor: pop expected reports for the edge just taken and compare (R11).
  always @(negedge clk) begin
    if (rst_n && edge_n > 0 && !done) begin
      for (int s = 0; s < 6; s++) begin
        int idx;
        idx = -1;
        for (int i = 0; i < sb.size(); i++)
          if (sb[i].due == edge_n && sb[i].slot == s) idx = i;
        if (idx >= 0) begin
          checks++;
          if (!wb_valid[s] || wb_rd[5*s +: 5] != sb[idx].rd || wb_data[32*s +: 32] != sb[idx].data) begin
            errors++;
            $display("FAIL R11 slot %0d edge %0d act v%0d r%0d %0h exp r%0d %0h", s, edge_n,
                     wb_valid[s], wb_rd[5*s +: 5], wb_data[32*s +: 32], sb[idx].rd, sb[idx].data);
          end
          sb.delete(idx);
        end else if (wb_valid[s]) begin
          checks++; errors++;
          $display("FAIL R7/R11 slot %0d edge %0d act unexpected r%0d %0h exp none", s, edge_n,
                   wb_rd[5*s +: 5], wb_data[32*s +: 32]);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act hung exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) ref_rf[i] = '0;
    for (int i = 0; i < 64; i++) ref_mem[i] = '0;
    for (int i = 0; i < 16; i++) begin
      for (int s = 0; s < 6; s++) pw_v[i][s] = 0;
      for (int m = 0; m < 2; m++) ps_v[i][m] = 0;
    end
    for (int s = 0; s < 6; s++) bw[s] = '0;
    repeat (3) @(posedge clk);
    #2 chk(wb_valid == 6'd0, "R12 wb idle in reset", {26'd0, wb_valid}, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    probe(5, 32'd0, "R12 reg zero after reset");

    // R2: latency 1, next bundle sees the result
    bw[0] = mk(ADDI, 1, 0, 0, 5); bw[1] = mk(ADDI, 2, 0, 0, 7); go();
    bw[0] = mk(ADD, 5, 1, 1, 0); bw[1] = mk(SUB, 6, 2, 1, 0); go();
    probe(5, 32'd10, "R2 add after one cycle");
    probe(6, 32'd2, "R2 sub");

    // R5: same-bundle RAW reads the old value
    bw[0] = mk(ADDI, 3, 0, 0, 100); bw[1] = mk(ADD, 4, 3, 1, 0); go();
    probe(4, 32'd5, "R5 same bundle reads old r3");
    probe(3, 32'd100, "R5 producer wrote");

    // R3: store at edge t+2, loads at issue
    bw[2] = mk(ST, 0, 0, 2, 4); go();
    bw[2] = mk(LD, 6, 0, 0, 4); go();
    bw[3] = mk(LD, 7, 0, 0, 4); go();
    bw[2] = mk(LD, 8, 0, 0, 4); go();
    idle(3);
    probe(6, 32'd0, "R3 load one after store old");
    probe(7, 32'd0, "R3 load two after store old");
    probe(8, 32'd7, "R3 load three after store new");
    // R6: under-padded consumer of a load
    bw[2] = mk(LD, 9, 0, 0, 4); go();
    idle(1);
    bw[0] = mk(ADD, 15, 9, 0, 0); go();
    bw[0] = mk(ADD, 16, 9, 0, 0); go();
    probe(15, 32'd0, "R6 early consumer stale");
    probe(16, 32'd7, "R3 load latency three");

    // R4: arithmetic latency 4
    bw[4] = mk(FMUL, 10, 1, 2, 0); bw[5] = mk(FADD, 17, 1, 2, 0); go();
    idle(2);
    bw[0] = mk(ADD, 11, 10, 0, 0); go();
    bw[0] = mk(ADD, 12, 10, 0, 0); go();
    probe(11, 32'd0, "R4 consumer at three stale");
    probe(12, 32'd35, "R4 fmul at four");
    probe(17, 32'd12, "R4 fadd");

    // R9: collisions, same class and across classes
    bw[0] = mk(ADDI, 18, 0, 0, 1); bw[1] = mk(ADDI, 18, 0, 0, 2); go();
    probe(18, 32'd1, "R9 slot0 beats slot1");
    bw[4] = mk(FADD, 19, 1, 1, 0); go();
    idle(2);
    bw[1] = mk(ADDI, 19, 0, 0, 9); go();
    idle(1);
    probe(19, 32'd9, "R9 slot1 beats slot4 same edge");

    // R10 and R1 signed immediates
    bw[2] = mk(ST, 0, 0, 1, 8); bw[3] = mk(ST, 0, 0, 2, 8); go();
    bw[0] = mk(ADDI, 21, 0, 0, 10); go();
    idle(2);
    bw[2] = mk(LD, 20, 0, 0, 8); bw[3] = mk(LD, 22, 21, 0, -2); bw[0] = mk(ADDI, 23, 1, 0, -3); go();
    idle(3);
    probe(20, 32'd5, "R10 slot2 store wins");
    probe(22, 32'd5, "R1 negative load offset");
    probe(23, 32'd2, "R1 negative immediate");

    // R7: wrong class, NOP, and invalid bundle
    bw[2] = mk(ADD, 24, 1, 2, 0); bw[4] = mk(ADDI, 25, 0, 0, 3); bw[0] = mk(LD, 26, 0, 0, 4);
    bw[1] = mk(NOP, 24, 1, 1, 0); go();
    bw[0] = mk(ADDI, 27, 0, 0, 55); bw[2] = mk(ST, 0, 0, 1, 4); go(0);
    idle(4);
    probe(24, 32'd0, "R7 int op in mem slot");
    probe(25, 32'd0, "R7 int op in arith slot");
    probe(26, 32'd0, "R7 load in int slot");
    probe(27, 32'd0, "R7 invalid bundle");
    bw[2] = mk(LD, 28, 0, 0, 4); go();
    idle(3);
    probe(28, 32'd7, "R7 invalid bundle no store");

    // R8: register 0
    bw[0] = mk(ADDI, 0, 0, 0, 9); go();
    @(posedge clk); #2;
    chk(wb_valid[0] == 1'b0, "R8 r0 write not reported", {31'd0, wb_valid[0]}, 32'd0);
    bw[0] = mk(ADD, 29, 0, 0, 0); go();
    probe(29, 32'd0, "R8 r0 reads zero");

    // Loop body B[i] = A[i] + C, C in r2, A at 32.., B at 48..
    for (int i = 0; i < 4; i++) begin
      bw[0] = mk(ADDI, 29, 0, 0, 3*i + 1); go();
      bw[2] = mk(ST, 0, 0, 29, 32 + i); go();
    end
    idle(3);
    bw[2] = mk(LD, 20, 0, 0, 32); bw[3] = mk(LD, 21, 0, 0, 33); go();
    bw[2] = mk(LD, 22, 0, 0, 34); bw[3] = mk(LD, 23, 0, 0, 35); go();
    idle(1);
    bw[4] = mk(FADD, 24, 20, 2, 0); bw[5] = mk(FADD, 25, 21, 2, 0); go();
    bw[4] = mk(FADD, 26, 22, 2, 0); bw[5] = mk(FADD, 27, 23, 2, 0); go();
    idle(2);
    bw[2] = mk(ST, 0, 0, 24, 48); bw[3] = mk(ST, 0, 0, 25, 49); go();
    bw[2] = mk(ST, 0, 0, 26, 50); bw[3] = mk(ST, 0, 0, 27, 51); go();
    idle(2);
    bw[2] = mk(LD, 10, 0, 0, 48); bw[3] = mk(LD, 11, 0, 0, 49); go();
    bw[2] = mk(LD, 12, 0, 0, 50); bw[3] = mk(LD, 13, 0, 0, 51); go();
    idle(3);
    probe(10, 32'd8,  "R4 loop B0");
    probe(11, 32'd11, "R4 loop B1");
    probe(12, 32'd14, "R4 loop B2");
    probe(13, 32'd17, "R3 loop B3");

    // R6: under-padded schedule reads stale r20
    bw[0] = mk(ADDI, 20, 0, 0, 100); go();
    bw[2] = mk(LD, 20, 0, 0, 32); go();
    idle(1);
    bw[4] = mk(FADD, 24, 20, 2, 0); go();
    idle(4);
    probe(24, 32'd107, "R6 under-padded fadd stale");
    probe(20, 32'd1, "R6 load landed later");

    idle(6);
    chk(sb.size() == 0, "R11 all reports seen", sb.size(), 32'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule